// File: doc/BRIEF.md
# Aging-Counter Associative Tag Directory

This block is the tag side of a small fully associative cache. A requester presents a tag, a read/write flag and a valid strobe. The block compares the tag against every entry at once and answers one cycle later with hit or miss and an entry index. On a hit, the index names the matching entry. On a miss, it names the entry that was just allocated for the new tag. Every miss allocates, whether it came from a read or a write.

Each entry keeps a tag, a valid flag, a dirty flag and a small age counter. A prescaler raises a tick once per programmed interval. Each tick ages every entry by one, and the count saturates. A reference by a hit returns the entry's age to zero. When a miss must replace a valid entry, the oldest entry is chosen. If that entry holds modified data, the response carries a write-back request that names the tag being displaced.

Top module: `age_repl_dir`

## Requirements
- R1: A request whose tag equals the tag of a valid entry produces, on the clock edge that samples it, `rsp_valid`=1, `rsp_hit`=1 and `rsp_index` equal to that entry. Outputs are readable in the following cycle. `rsp_valid` is 0 after any edge that sampled no request.
- R2: A request that matches no valid entry produces `rsp_hit`=0 and writes its tag into the entry given by `rsp_index`. A later request for that tag hits at that index until the entry is replaced.
- R3: While any entry is invalid, a miss takes the invalid entry with the lowest index, whatever the ages of the valid entries.
- R4: When all entries are valid, a miss replaces the entry with the largest age. Among equal ages, the lowest index wins.
- R5: On every tick, each entry's age rises by one and stops at 2^AGE_W-1 (7 by default) without wrapping.
- R6: A hit clears the referenced entry's age to zero, even when a tick falls on the same edge. A newly allocated entry also starts at age zero.
- R7: With `tick_interval`=N, ticks fall on every (N+1)-th clock edge, counted from the end of reset. N=0 ticks on every edge.
- R8: A write hit marks the entry dirty. An allocation caused by a write miss starts dirty, and one caused by a read miss starts clean.
- R9: A miss that replaces a valid dirty entry raises `wb_valid`=1 in the same cycle as its response, with `wb_tag` equal to the displaced tag. A clean or invalid victim gives `wb_valid`=0.
- R10: A synchronous reset clears all valid flags, dirty flags, ages and the prescaler, and drives `rsp_valid` and `wb_valid` to 0. After reset, every tag misses and no write-back is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| tick_interval | input | DIV_W | Tick every tick_interval+1 cycles |
| req_valid | input | 1 | Lookup request strobe |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_tag | input | TAG_W | Tag to look up |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | 1 = hit, 0 = miss |
| rsp_index | output | IDX_W | Matching or newly allocated entry |
| wb_valid | output | 1 | Displaced dirty entry needs a write-back |
| wb_tag | output | TAG_W | Tag of the displaced entry |

## Verification
The properties assume that `req_valid`, `req_write` and `req_tag` carry known values at every sampling edge. They also rely on the directory never holding the same tag twice, which holds because only a miss allocates. The stimulus drives all inputs on falling edges and changes `tick_interval` only in idle cycles. Each aging scenario starts from a fresh reset, so the exact edge of every tick can be counted. Victim choices are then compared against ages worked out by hand for each entry.

// File: rtl/age_repl_dir.sv
module age_repl_dir #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 16,
  parameter int AGE_W   = 3,
  parameter int DIV_W   = 8,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] tick_interval,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [TAG_W-1:0] req_tag,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [IDX_W-1:0] rsp_index,
  output logic             wb_valid,
  output logic [TAG_W-1:0] wb_tag
);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  logic [ENTRIES-1:0][TAG_W-1:0] tag_q;
  logic [ENTRIES-1:0][AGE_W-1:0] age_q;
  logic [ENTRIES-1:0]            vld_q, dty_q, hit_vec;
  logic [DIV_W-1:0]              div_q;
  logic                          tick, hit_any, evict_dirty;
  logic [IDX_W-1:0]              hit_idx, vic_idx, sel_idx;

  assign tick = div_q >= tick_interval;

  always_ff @(posedge clk) begin
    if (rst)       div_q <= '0;
    else if (tick) div_q <= '0;
    else           div_q <= div_q + 1'b1;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = vld_q[g] && (tag_q[g] == req_tag);
  end

  assign hit_any = |hit_vec;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hit_vec[i]) hit_idx = IDX_W'(i);
  end

  always_comb begin
    logic             found;
    logic [AGE_W-1:0] best;
    found   = 1'b0;
    vic_idx = '0;
    best    = age_q[0];
    for (int i = 0; i < ENTRIES; i++)
      if (!vld_q[i] && !found) begin
        vic_idx = IDX_W'(i);
        found   = 1'b1;
      end
    if (!found)
      for (int i = 1; i < ENTRIES; i++)
        if (age_q[i] > best) begin
          best    = age_q[i];
          vic_idx = IDX_W'(i);
        end
  end

  assign sel_idx     = hit_any ? hit_idx : vic_idx;
  assign evict_dirty = !hit_any && vld_q[vic_idx] && dty_q[vic_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      dty_q <= '0;
      age_q <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (req_valid && sel_idx == IDX_W'(i)) begin
          age_q[i] <= '0;
          if (!hit_any) begin
            vld_q[i] <= 1'b1;
            tag_q[i] <= req_tag;
            dty_q[i] <= req_write;
          end else if (req_write) begin
            dty_q[i] <= 1'b1;
          end
        end else if (tick && age_q[i] != AGE_MAX) begin
          age_q[i] <= age_q[i] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_index <= '0;
      wb_valid  <= 1'b0;
      wb_tag    <= '0;
    end else begin
      rsp_valid <= req_valid;
      wb_valid  <= req_valid && evict_dirty;
      if (req_valid) begin
        rsp_hit   <= hit_any;
        rsp_index <= sel_idx;
        wb_tag    <= tag_q[vic_idx];
      end
    end
  end
endmodule

module age_repl_dir_chk #(
  parameter int ENTRIES = 8,
  parameter int AGE_W   = 3
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          req_valid,
  input logic                          req_write,
  input logic                          tick,
  input logic [ENTRIES-1:0]            hit_vec,
  input logic [ENTRIES-1:0]            vld,
  input logic [ENTRIES-1:0]            dty,
  input logic [ENTRIES-1:0][AGE_W-1:0] ages,
  input logic                          rsp_valid,
  input logic                          rsp_hit,
  input logic                          wb_valid
);
  localparam logic [AGE_W-1:0] AGE_TOP = '1;

  a_r1_single_match: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));
  a_r1_rsp_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  a_r1_no_rsp: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  a_r9_wb_on_miss: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> (rsp_valid && !rsp_hit));
  a_r9_no_wb_free: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !(&vld) && !(|hit_vec)) |=> !wb_valid);
  a_r8_write_hit_dirty: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && |hit_vec) |=> ((dty & $past(hit_vec)) == $past(hit_vec)));
  a_r10_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (vld == '0 && dty == '0 && !rsp_valid && !wb_valid));

  for (genvar g = 0; g < ENTRIES; g++) begin : g_age
    a_r6_ref_clears: assert property (@(posedge clk) disable iff (rst)
      (req_valid && hit_vec[g]) |=> ages[g] == '0);
    a_r5_saturate: assert property (@(posedge clk) disable iff (rst)
      (!req_valid && ages[g] == AGE_TOP) |=> ages[g] == AGE_TOP);
    a_r5_step: assert property (@(posedge clk) disable iff (rst)
      !req_valid |=> (ages[g] == $past(ages[g]) || ages[g] == AGE_W'($past(ages[g]) + 1'b1)));
    a_r7_no_tick_hold: assert property (@(posedge clk) disable iff (rst)
      (!req_valid && !tick) |=> $stable(ages[g]));
  end
endmodule

bind age_repl_dir age_repl_dir_chk #(.ENTRIES(ENTRIES), .AGE_W(AGE_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write), .tick(tick),
  .hit_vec(hit_vec), .vld(vld_q), .dty(dty_q), .ages(age_q),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .wb_valid(wb_valid)
);

// File: tb/sim_age_repl_dir.sv
module sim_age_repl_dir;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  tick_interval = 8'd255;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_tag = '0;
  logic        rsp_valid, rsp_hit, wb_valid;
  logic [2:0]  rsp_index;
  logic [15:0] wb_tag;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  age_repl_dir u0 (
    .clk(clk), .rst(rst), .tick_interval(tick_interval),
    .req_valid(req_valid), .req_write(req_write), .req_tag(req_tag),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_index(rsp_index),
    .wb_valid(wb_valid), .wb_tag(wb_tag)
  );

  // {write, tag, exp_hit, exp_idx, exp_wb, exp_wbtag}
  localparam logic [37:0] VEC [14] = '{
    {1'b1, 16'h0010, 1'b0, 3'd0, 1'b0, 16'h0000},
    {1'b0, 16'h0011, 1'b0, 3'd1, 1'b0, 16'h0000},
    {1'b0, 16'h0012, 1'b0, 3'd2, 1'b0, 16'h0000},
    {1'b0, 16'h0013, 1'b0, 3'd3, 1'b0, 16'h0000},
    {1'b0, 16'h0014, 1'b0, 3'd4, 1'b0, 16'h0000},
    {1'b0, 16'h0015, 1'b0, 3'd5, 1'b0, 16'h0000},
    {1'b0, 16'h0016, 1'b0, 3'd6, 1'b0, 16'h0000},
    {1'b0, 16'h0017, 1'b0, 3'd7, 1'b0, 16'h0000},
    {1'b0, 16'h0012, 1'b1, 3'd2, 1'b0, 16'h0000},
    {1'b1, 16'h0013, 1'b1, 3'd3, 1'b0, 16'h0000},
    {1'b0, 16'h0010, 1'b1, 3'd0, 1'b0, 16'h0000},
    {1'b0, 16'h0020, 1'b0, 3'd0, 1'b1, 16'h0010},
    {1'b0, 16'h0021, 1'b0, 3'd0, 1'b0, 16'h0000},
    {1'b0, 16'h0020, 1'b0, 3'd0, 1'b0, 16'h0000}
  };

  task automatic check(input string id, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", id, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic req(input logic w, input logic [15:0] t, input logic eh,
                     input logic [2:0] ei, input logic ew, input logic [15:0] et,
                     input string id);
    req_valid = 1'b1;
    req_write = w;
    req_tag   = t;
    @(negedge clk);
    req_valid = 1'b0;
    req_write = 1'b0;
    check({id, " valid"}, 32'(rsp_valid), 32'd1);
    check({id, " hit"}, 32'(rsp_hit), 32'(eh));
    check({id, " index"}, 32'(rsp_index), 32'(ei));
    check({id, " wb"}, 32'(wb_valid), 32'(ew));
    if (ew) check({id, " wb_tag"}, 32'(wb_tag), 32'(et));
  endtask

  initial begin
    #(8 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick_interval = 8'd255;
    do_reset();
    check("R10 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    check("R10 wb_valid after reset", 32'(wb_valid), 32'd0);

    for (int k = 0; k < 14; k++) begin
      logic [37:0] v;
      v = VEC[k];
      req(v[37], v[36:21], v[20], v[19:17], v[16], v[15:0],
          v[16] ? "R9 R4 table evict" : (v[20] ? "R1 table hit" : "R2 R8 table miss"));
    end
    idle(1);
    check("R1 no response when idle", 32'(rsp_valid), 32'd0);

    req(1'b1, 16'h0020, 1'b1, 3'd0, 1'b0, 16'h0, "R8 write hit");
    do_reset();
    check("R10 rsp_valid after second reset", 32'(rsp_valid), 32'd0);
    req(1'b0, 16'h0020, 1'b0, 3'd0, 1'b0, 16'h0, "R10 cached tag misses after reset");

    // invalid entries taken first
    tick_interval = 8'd0;
    do_reset();
    req(1'b0, 16'h0060, 1'b0, 3'd0, 1'b0, 16'h0, "R3 fill 0");
    req(1'b0, 16'h0061, 1'b0, 3'd1, 1'b0, 16'h0, "R3 fill 1");
    req(1'b0, 16'h0062, 1'b0, 3'd2, 1'b0, 16'h0, "R3 fill 2");
    idle(4);
    req(1'b0, 16'h0070, 1'b0, 3'd3, 1'b0, 16'h0, "R3 invalid before aged");
    req(1'b0, 16'h0061, 1'b1, 3'd1, 1'b0, 16'h0, "R1 hit after aging");

    // aging, saturation, reference clearing
    tick_interval = 8'd255;
    do_reset();
    for (int k = 0; k < 8; k++)
      req(1'b0, 16'h0040 + 16'(k), 1'b0, 3'(k), 1'b0, 16'h0, "R3 aging fill");
    req(1'b1, 16'h0041, 1'b1, 3'd1, 1'b0, 16'h0, "R8 write hit dirties");
    tick_interval = 8'd0;
    idle(2);
    req(1'b0, 16'h0040, 1'b1, 3'd0, 1'b0, 16'h0, "R6 hit with tick");
    idle(5);
    tick_interval = 8'd255;
    req(1'b0, 16'h0050, 1'b0, 3'd1, 1'b1, 16'h0041, "R5 R9 saturated oldest dirty");
    req(1'b0, 16'h0051, 1'b0, 3'd2, 1'b0, 16'h0, "R5 R9 next oldest clean");
    req(1'b0, 16'h0052, 1'b0, 3'd3, 1'b0, 16'h0, "R6 referenced entry younger");

    // prescaler interval: tick every 4th edge
    tick_interval = 8'd3;
    do_reset();
    for (int k = 0; k < 8; k++)
      req(1'b0, 16'h0080 + 16'(k), 1'b0, 3'(k), 1'b0, 16'h0, "R7 fill");
    req(1'b0, 16'h0080, 1'b1, 3'd0, 1'b0, 16'h0, "R7 hit 0");
    req(1'b0, 16'h0081, 1'b1, 3'd1, 1'b0, 16'h0, "R7 hit 1");
    req(1'b0, 16'h0082, 1'b1, 3'd2, 1'b0, 16'h0, "R7 hit 2");
    req(1'b0, 16'h0090, 1'b0, 3'd3, 1'b0, 16'h0, "R7 victim after two ticks");
    req(1'b0, 16'h0091, 1'b0, 3'd4, 1'b0, 16'h0, "R7 victim after third tick");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule